// File: doc/BRIEF.md
# Zero-Cross Mute Detector for Stereo Transmit Samples

This block sits beside the transmit path of a stereo audio serial port and looks at each sample word as it is handed to the shifter. For every channel, with detection switched on, it compares the sign of the incoming sample with the sign of the previous sample that went out on the same channel. If the two signs differ, or if every bit of the sample inside the selected word width is zero, it raises a sticky flag for that channel. From then on the channel transmits zero words, until software writes a one to the matching clear bit.

The sample word, its channel tag, a load strobe and the word-width select come from the serialiser. The block gives back the word to shift, which is the sample masked to the selected width or zero when the channel is muted, one cycle after the load. It also gives the per-channel flags and the per-channel interrupt lines. Left is channel 0 and right is channel 1. The supported word widths are whole multiples of a lane, which is 8, 16, 24 or 32 bits with the default parameters.

Top module: `zc_mute_top`

## Requirements
- R1: After reset, both flags, both interrupt lines, `word_out` and `word_vld` are 0, and the stored previous sign of each channel is 0.
- R2: `width_sel` picks the active width: 0 selects 8 bits, 1 selects 16, 2 selects 24 and 3 selects 32. The sign is bit width-1. A load on a channel whose detection is enabled sets that channel's flag when this sign differs from the channel's stored previous sign.
- R3: A load on a channel whose detection is enabled also sets the flag when all sample bits below the active width are zero. Bits at or above the width are ignored for this test.
- R4: Each channel keeps its own previous sign and its own flag. `chan` = 0 addresses left (bit 0 of every per-channel vector) and `chan` = 1 addresses right (bit 1). A load on one channel never changes the other channel's state.
- R5: One cycle after a load, `word_vld` is 1 for exactly one cycle. `word_out` is the sample with the bits at or above the active width forced to 0. If the channel's flag was already set, or this load itself raises the flag, `word_out` is all zeros instead.
- R6: A cycle with `clr_wr` = 1 clears every flag whose bit is 1 in `clr_mask`, effective the next cycle. If a detect event on the same channel happens in the same cycle, the flag stays set.
- R7: `irq[c]` is 1 exactly when the flag of channel c and `irq_en[c]` are both 1.
- R8: While `det_en[c]` is 0, loads on channel c never set its flag, and its previous sign is held at 0. After detection is re-enabled, a first sample with a positive sign and nonzero data gives no event.
- R9: A set flag stays set across any number of later loads and across disabling detection, until a clear removes it. While the flag is set, the channel is muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 2 | Detection enable per channel |
| irq_en | input | 2 | Interrupt enable per channel |
| clr_wr | input | 1 | Flag-clear write strobe |
| clr_mask | input | 2 | Write-1-to-clear mask for the flags |
| load | input | 1 | A sample is being loaded this cycle |
| chan | input | 1 | Channel of the loaded sample (0 left, 1 right) |
| width_sel | input | 2 | Active word width select |
| sample_in | input | 32 | Sample word being loaded |
| word_out | output | 32 | Word handed to the shifter, masked or muted |
| word_vld | output | 1 | `word_out` was updated by a load in the previous cycle |
| zc_flag | output | 2 | Sticky zero-cross flag per channel |
| irq | output | 2 | Per-channel interrupt request |

## Verification
On every cycle, the assertions check the pieces of behaviour that need no sample arithmetic. A clear with no competing load empties its flag. Flags do not move in idle cycles, and a flag can only rise after an enabled load on its own channel. An all-zero word always trips the detector. A load on a flagged channel yields a zero word, `word_vld` follows `load` by one cycle, and an interrupt line is never high without its flag. The sign comparison against the stored history only shows up in the bench's scenarios, which drive random samples and widths against a reference model. The same holds for masking at each width, the reset of the history while detection is off, and the priority of a set over a clear in the same cycle.

// File: rtl/zc_pkg.sv
`timescale 1ns/1ps
package zc_pkg;
   // number of lanes enabled for a given width select (select k -> k+1 lanes)
   function automatic int unsigned lanes_for(input int unsigned sel);
      return sel + 1;
   endfunction
endpackage

// File: rtl/zc_width_view.sv
`timescale 1ns/1ps
module zc_width_view #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned NUM_L = DATA_W / LANE_W,
   localparam int unsigned SEL_W = (NUM_L > 1) ? $clog2(NUM_L) : 1
) (
   input  logic [DATA_W-1:0] sample,
   input  logic [SEL_W-1:0]  wsel,
   output logic [DATA_W-1:0] masked,
   output logic              sign_bit,
   output logic              is_zero
);
   logic [NUM_L-1:0] lane_on;
   logic [NUM_L-1:0] lane_sign;
   logic [NUM_L-1:0] lane_nz;

   for (genvar k = 0; k < NUM_L; k++) begin : g_lane
      assign lane_on[k]   = (int'(wsel) >= k);
      assign masked[k*LANE_W +: LANE_W] = lane_on[k] ? sample[k*LANE_W +: LANE_W] : '0;
      assign lane_sign[k] = sample[k*LANE_W + LANE_W - 1];
      assign lane_nz[k]   = lane_on[k] & (|sample[k*LANE_W +: LANE_W]);
   end

   always_comb begin
      sign_bit = 1'b0;
      for (int k = 0; k < NUM_L; k++) begin
         if (int'(wsel) == k) sign_bit = lane_sign[k];
      end
   end

   assign is_zero = ~(|lane_nz);
endmodule

// File: rtl/zc_chan_tracker.sv
`timescale 1ns/1ps
module zc_chan_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic hit,
   input  logic sign_bit,
   input  logic is_zero,
   input  logic clr,
   output logic flag,
   output logic event_now
);
   logic prev_sign;

   assign event_now = hit & enable & ((sign_bit ^ prev_sign) | is_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sign <= 1'b0;
      end else if (!enable) begin
         prev_sign <= 1'b0;
      end else if (hit) begin
         prev_sign <= sign_bit;
      end
   end

   // set has priority over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (event_now) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/zc_out_stage.sv
`timescale 1ns/1ps
module zc_out_stage #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              mute,
   input  logic [DATA_W-1:0] masked,
   output logic [DATA_W-1:0] word_out,
   output logic              word_vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_out <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= load;
         if (load) word_out <= mute ? '0 : masked;
      end
   end
endmodule

// File: rtl/zc_mute_top.sv
`timescale 1ns/1ps
module zc_mute_top #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned NUM_CH = 2,
   localparam int unsigned NUM_L = DATA_W / LANE_W,
   localparam int unsigned SEL_W = (NUM_L > 1) ? $clog2(NUM_L) : 1,
   localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] det_en,
   input  logic [NUM_CH-1:0] irq_en,
   input  logic              clr_wr,
   input  logic [NUM_CH-1:0] clr_mask,
   input  logic              load,
   input  logic [CH_W-1:0]   chan,
   input  logic [SEL_W-1:0]  width_sel,
   input  logic [DATA_W-1:0] sample_in,
   output logic [DATA_W-1:0] word_out,
   output logic              word_vld,
   output logic [NUM_CH-1:0] zc_flag,
   output logic [NUM_CH-1:0] irq
);
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end

   logic [DATA_W-1:0] masked;
   logic              sign_bit;
   logic              is_zero;
   logic [NUM_CH-1:0] event_vec;
   logic              mute;

   zc_width_view #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_view (
      .sample   (sample_in),
      .wsel     (width_sel),
      .masked   (masked),
      .sign_bit (sign_bit),
      .is_zero  (is_zero)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      zc_chan_tracker u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (det_en[c]),
         .hit       (load && (int'(chan) == c)),
         .sign_bit  (sign_bit),
         .is_zero   (is_zero),
         .clr       (clr_wr & clr_mask[c]),
         .flag      (zc_flag[c]),
         .event_now (event_vec[c])
      );
   end

   always_comb begin
      mute = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (int'(chan) == c) mute = zc_flag[c] | event_vec[c];
      end
   end

   zc_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .mute     (mute),
      .masked   (masked),
      .word_out (word_out),
      .word_vld (word_vld)
   );

   assign irq = zc_flag & irq_en;
endmodule

// File: rtl/zc_mute_checker.sv
`timescale 1ns/1ps
module zc_mute_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned CH_W   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] det_en,
   input logic              clr_wr,
   input logic [NUM_CH-1:0] clr_mask,
   input logic              load,
   input logic [CH_W-1:0]   chan,
   input logic [DATA_W-1:0] sample_in,
   input logic [DATA_W-1:0] word_out,
   input logic              word_vld,
   input logic [NUM_CH-1:0] zc_flag,
   input logic [NUM_CH-1:0] irq
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R6: clear with no competing load on the channel empties the flag
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
         clr_wr && clr_mask[c] && !(load && int'(chan) == c) |=> !zc_flag[c]);
      // R8: a flag only rises after an enabled load on its own channel
      a_r8_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(zc_flag[c]) |-> $past(load && int'(chan) == c && det_en[c]));
      // R3: an all-zero word always trips an enabled detector
      a_r3_zero_trips: assert property (@(posedge clk) disable iff (!rst_n)
         load && int'(chan) == c && det_en[c] && sample_in == '0 |=> zc_flag[c]);
      // R7: no interrupt without its flag
      a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
         !zc_flag[c] |-> !irq[c]);
   end

   // R9: flags hold when nothing touches them
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr && !load |=> $stable(zc_flag));
   // R5: a flagged channel emits zero
   a_r5_muted: assert property (@(posedge clk) disable iff (!rst_n)
      load && zc_flag[chan] |=> word_out == '0);
   // R5: valid follows load by one cycle
   a_r5_vld_on: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> word_vld);
   a_r5_vld_off: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> !word_vld);
endmodule

bind zc_mute_top zc_mute_checker #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_zc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .det_en    (det_en),
   .clr_wr    (clr_wr),
   .clr_mask  (clr_mask),
   .load      (load),
   .chan      (chan),
   .sample_in (sample_in),
   .word_out  (word_out),
   .word_vld  (word_vld),
   .zc_flag   (zc_flag),
   .irq       (irq)
);

// File: tb/zc_mute_top_bench.sv
`timescale 1ns/1ps
module zc_mute_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  det_en = '0;
   logic [1:0]  irq_en = '0;
   logic        clr_wr = 1'b0;
   logic [1:0]  clr_mask = '0;
   logic        load = 1'b0;
   logic        chan = 1'b0;
   logic [1:0]  width_sel = '0;
   logic [31:0] sample_in = '0;
   logic [31:0] word_out;
   logic        word_vld;
   logic [1:0]  zc_flag;
   logic [1:0]  irq;

   int unsigned total = 0;
   int unsigned bad = 0;
   bit          done = 1'b0;

   logic [1:0] m_prev;
   logic [1:0] m_flag;

   always #2.5 clk = ~clk;

   zc_mute_top u_zc_mute_top (
      .clk(clk), .rst_n(rst_n), .det_en(det_en), .irq_en(irq_en),
      .clr_wr(clr_wr), .clr_mask(clr_mask), .load(load), .chan(chan),
      .width_sel(width_sel), .sample_in(sample_in), .word_out(word_out),
      .word_vld(word_vld), .zc_flag(zc_flag), .irq(irq)
   );

   function automatic logic [31:0] wmask(input logic [1:0] w);
      return (w == 2'd3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (int'(w) + 1))) - 32'd1);
   endfunction

   function automatic logic wsign(input logic [31:0] s, input logic [1:0] w);
      return s[8 * (int'(w) + 1) - 1];
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic ld, input logic ch, input logic [1:0] w, input logic [31:0] s,
                       input logic clr, input logic [1:0] cm, input logic [1:0] den,
                       input logic [1:0] ien, input string tag);
      logic        ev;
      logic        sg;
      logic [31:0] expo;
      logic [1:0]  nf;
      @(negedge clk);
      load = ld; chan = ch; width_sel = w; sample_in = s;
      clr_wr = clr; clr_mask = cm; det_en = den; irq_en = ien;
      sg   = wsign(s, w);
      ev   = ld && den[ch] && ((sg != m_prev[ch]) || ((s & wmask(w)) == 32'd0));
      expo = (m_flag[ch] || ev) ? 32'd0 : (s & wmask(w));
      nf   = m_flag;
      if (clr) nf = nf & ~cm;
      if (ev) nf[ch] = 1'b1;
      for (int c = 0; c < 2; c++) begin
         if (!den[c]) m_prev[c] = 1'b0;
         else if (ld && ch == c[0]) m_prev[c] = sg;
      end
      m_flag = nf;
      @(posedge clk);
      #1;
      check(zc_flag == nf, {tag, " flag"}, {30'd0, zc_flag}, {30'd0, nf});
      check(irq == (nf & ien), "R7 irq", {30'd0, irq}, {30'd0, nf & ien});
      check(word_vld == ld, "R5 vld", {31'd0, word_vld}, {31'd0, ld});
      if (ld) check(word_out == expo, {tag, " word"}, word_out, expo);
      load = 1'b0; clr_wr = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_prev = '0;
      m_flag = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(zc_flag == 2'b00, "R1 flags", {30'd0, zc_flag}, 32'd0);
      check(irq == 2'b00, "R1 irq", {30'd0, irq}, 32'd0);
      check(word_out == 32'd0, "R1 word", word_out, 32'd0);
      check(word_vld == 1'b0, "R1 vld", {31'd0, word_vld}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: 8-bit width, positive then sign flip on left
      step(1, 0, 2'd0, 32'hFFFF_FF7F, 0, 2'b00, 2'b11, 2'b11, "R2 pos8");
      step(1, 0, 2'd0, 32'h0000_0080, 0, 2'b00, 2'b11, 2'b11, "R2 flip8");
      // R4: right channel unaffected by left flag
      step(1, 1, 2'd1, 32'h0000_1234, 0, 2'b00, 2'b11, 2'b11, "R4 right");
      // R9: left stays muted on later loads
      step(1, 0, 2'd0, 32'h0000_0081, 0, 2'b00, 2'b11, 2'b11, "R9 sticky");
      // R6: clear left
      step(0, 0, 2'd0, 32'h0, 1, 2'b01, 2'b11, 2'b11, "R6 clear");
      // R3: zero within 16 bits, nonzero above, on right
      step(1, 1, 2'd1, 32'hABCD_0000, 0, 2'b00, 2'b11, 2'b11, "R3 zero16");
      // R6: clear and event together, set wins
      step(1, 1, 2'd1, 32'h0000_0000, 1, 2'b10, 2'b11, 2'b11, "R6 setwins");
      step(0, 0, 2'd0, 32'h0, 1, 2'b11, 2'b11, 2'b01, "R6 clrboth");
      // R8: disabled left ignores negative and zero samples
      step(1, 0, 2'd3, 32'h8000_0000, 0, 2'b00, 2'b10, 2'b11, "R8 dis neg");
      step(1, 0, 2'd3, 32'h0000_0000, 0, 2'b00, 2'b10, 2'b11, "R8 dis zero");
      // R8: re-enabled, positive nonzero gives no event
      step(1, 0, 2'd2, 32'h0000_0001, 0, 2'b00, 2'b11, 2'b11, "R8 reen");
      // R2: 24-bit sign flip
      step(1, 0, 2'd2, 32'h0080_0001, 0, 2'b00, 2'b11, 2'b11, "R2 flip24");
      step(0, 0, 2'd0, 32'h0, 1, 2'b11, 2'b11, 2'b11, "R6 clr");

      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         logic [1:0]  w;
         logic [31:0] s;
         logic [1:0]  den;
         w = 2'($urandom_range(0, 3));
         case ($urandom_range(0, 3))
            0: s = 32'd0;
            1: s = $urandom;
            2: s = $urandom & ~wmask(w);
            default: s = $urandom_range(1, 100);
         endcase
         den = ($urandom_range(0, 19) == 0) ? 2'($urandom) : det_en;
         step(1'($urandom_range(0, 3) != 0), 1'($urandom), w, s,
              ($urandom_range(0, 4) == 0), 2'($urandom), den, 2'($urandom), "R2/R3/R4 rand");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule